// File: doc/BRIEF.md
# ADC Configuration Bank with Result Formatter

This block holds the per-entry settings that an ADC sequencer steps through. There are 32 entries of 16 bits each. Software reaches them through one data port and a 5-bit pointer. The pointer can be loaded directly. After every accepted write it moves on by one, so a run of writes fills neighbouring entries. Writes only take effect when the port is routed to the bank and no conversion is running. Reads are always allowed and return the entry under the pointer.

The entry under the pointer is split into its fields and shown on outputs. These fields are gain, alternate destination, acquisition extension, alignment, differential mode and channel. A combinational flag marks channel codes that are not valid for the selected mode, so the sequencer can skip that entry.

A second path formats conversion results. When the converter signals that a conversion has finished, the block takes the 14-bit signed result for the named entry. It packs the result into a 16-bit word, left or right aligned as that entry selects. It also picks the store address: the entry number, or the entry's alternate location when the override input is high. One cycle later the block presents the word, the address and a write strobe.

Top module: `adc_cfg_bank`

## Requirements
- R1: A data-port write (`wr_en`=1) is accepted only when `cfg_sel`=1, `avg_sel`=0 and `conv_busy`=0. An accepted write stores `wr_data` into the entry under the pointer. A write refused for routing reasons changes no entry and leaves the pointer unchanged.
- R2: After each accepted write the pointer advances by one, wrapping from 31 to 0. A pulse on `idx_wr` loads `idx_wdata` into the pointer instead. `idx_o` shows the pointer.
- R3: While `conv_busy`=1, a data-port write changes no entry and leaves the pointer where it was.
- R4: A synchronous reset (`rst_n`=0 at a clock edge) clears all entries, the pointer, `res_we`, `res_addr` and `res_word` to zero.
- R5: Bit 15 of every entry is reserved. It always reads 0, whatever was written.
- R6: `rd_data` returns the entry under the pointer, and reading does not move the pointer. The decoded outputs come from that entry's bits: `sel_gain`=14:13, `sel_alt_loc`=12:8, `sel_acq_ext`=7, `sel_align_left`=6, `sel_diff`=5, `sel_chan`=4:0.
- R7: `sel_chan_invalid` is 1 for the entry under the pointer when its channel code is not valid. Codes 0–7, 16–19 and 25 are valid in both modes. Codes 8–15 are valid only when `sel_diff`=0. Codes 20–24 and 26–31 are never valid.
- R8: With the entry's alignment bit set, the result sits in word bits 15:2 and bits 1:0 are 0. With it clear, the result sits in bits 13:0 and bits 15:14 copy result bit 13.
- R9: `res_we` is high for exactly the one cycle after each `conv_done` strobe. `res_addr` is then `conv_entry` when `loc_override`=0, or that entry's alternate location when `loc_override`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Data port routed to the configuration bank |
| avg_sel | input | 1 | Data port routed to averaging settings (bank untouched) |
| conv_busy | input | 1 | Conversion in progress; blocks writes |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 16 | Data-port write value |
| idx_wr | input | 1 | Load the pointer |
| idx_wdata | input | 5 | New pointer value |
| idx_o | output | 5 | Current pointer |
| rd_data | output | 16 | Entry under the pointer |
| sel_gain | output | 2 | Gain code of the selected entry |
| sel_alt_loc | output | 5 | Alternate result location of the selected entry |
| sel_acq_ext | output | 1 | Acquisition extension enable of the selected entry |
| sel_align_left | output | 1 | Alignment select of the selected entry |
| sel_diff | output | 1 | Differential select of the selected entry |
| sel_chan | output | 5 | Channel code of the selected entry |
| sel_chan_invalid | output | 1 | Selected channel code is not valid |
| conv_done | input | 1 | Conversion finished strobe |
| conv_entry | input | 5 | Entry the finished conversion belongs to |
| conv_result | input | 14 | Signed conversion result |
| loc_override | input | 1 | Store the result at the entry's alternate location |
| res_we | output | 1 | Result store strobe |
| res_addr | output | 5 | Result store address |
| res_word | output | 16 | Formatted result word |

## Verification
A pointer that steps wrongly, wraps wrongly or moves on a refused write appears on `idx_o` one clock later. It also shows up when the next readback of `rd_data` comes from the wrong entry. A corrupted or wrongly gated entry appears on `rd_data` and on the decoded field outputs in the cycle after the pointer selects it. A wrong validity rule appears at once on `sel_chan_invalid`. Formatting and address faults appear on `res_word` and `res_addr` in the single cycle in which `res_we` is high after the strobe.

// File: rtl/adc_cfg_pkg.sv
`timescale 1ns/1ps
// adc_cfg_pkg
// Shared widths, the entry layout and the channel validity rule for the
// ADC configuration bank. Assumes the alternate-location field is as wide
// as the bank pointer (bank depth of 2**LOC_W entries).
package adc_cfg_pkg;

    localparam int GAIN_W = 2;
    localparam int LOC_W  = 5;
    localparam int CHAN_W = 5;
    localparam int WORD_W = 16;
    localparam int RES_W  = 14;

    // One configuration entry, most significant field first.
    typedef struct packed {
        logic              rsvd;
        logic [GAIN_W-1:0] gain;
        logic [LOC_W-1:0]  alt_loc;
        logic              acq_ext;
        logic              align_left;
        logic              diff;
        logic [CHAN_W-1:0] chan;
    } cfg_entry_t;

    // Returns 1 when a channel code may be converted in the given mode.
    function automatic logic chan_ok(input logic diff, input logic [CHAN_W-1:0] code);
        logic ok;
        if (code < 5'd8) begin
            ok = 1'b1;                 // external inputs, both modes
        end else if (code < 5'd16) begin
            ok = !diff;                // single-ended only
        end else if (code < 5'd20) begin
            ok = 1'b1;                 // internal sources
        end else begin
            ok = (code == 5'd25);      // offset source; rest reserved
        end
        return ok;
    endfunction

endpackage

// File: rtl/adc_cfg_regfile.sv
`timescale 1ns/1ps
// adc_cfg_regfile
// Storage for the configuration entries, the self-advancing pointer and the
// write gate. Port A follows the pointer; port B is addressed by the result
// path and returns only the fields the formatter needs.
// Assumes NUM_ENTRIES = 2**LOC_W so the pointer and alternate field match.
module adc_cfg_regfile
    import adc_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel,
    input  logic             avg_sel,
    input  logic             conv_busy,
    input  logic             wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    output logic [IDX_W-1:0] idx_q,
    output cfg_entry_t       rd_entry_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic             rd_align_b,
    output logic [LOC_W-1:0] rd_loc_b
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
    localparam logic [WORD_W-1:0] KEEP     = {1'b0, {(WORD_W-1){1'b1}}};

    cfg_entry_t mem [NUM_ENTRIES];
    logic       wr_accept;
    logic [IDX_W-1:0] idx_next;

    // Accept a write only when routed to the bank and the converter is idle.
    always_comb begin
        wr_accept = wr_en && cfg_sel && !avg_sel && !conv_busy;
    end

    // Next pointer value after an accepted write, wrapping at the last entry.
    always_comb begin
        if (idx_q == LAST_IDX) begin
            idx_next = '0;
        end else begin
            idx_next = idx_q + IDX_W'(1);
        end
    end

    // Pointer register: direct load wins over the post-write step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= idx_wdata;
        end else if (wr_accept) begin
            idx_q <= idx_next;
        end
    end

    // Entry storage: clear on reset, write the pointed entry, keep bit 15 clear.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_accept && (idx_q == IDX_W'(i))) begin
                mem[i] <= cfg_entry_t'(wr_data & KEEP);
            end
        end
    end

    // Read port A: entry under the pointer.
    always_comb begin
        rd_entry_a = mem[idx_q];
    end

    // Read port B: alignment and alternate location for the result path.
    always_comb begin
        rd_align_b = mem[rd_idx_b].align_left;
        rd_loc_b   = mem[rd_idx_b].alt_loc;
    end

    // An accepted write without a load moves the pointer on by one (R2).
    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !idx_wr) |=>
            (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + IDX_W'(1))));

    // A write during a conversion leaves pointer and pointed entry alone (R3).
    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && conv_busy && !idx_wr) |=> ($stable(idx_q) && $stable(rd_entry_a)));

    // An accepted write is visible in the target entry next cycle (R1).
    assert_wr_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> (mem[$past(idx_q)] == cfg_entry_t'($past(wr_data) & KEEP)));

    // A write not routed to the bank changes neither pointer nor entry (R1).
    assert_route_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!cfg_sel || avg_sel) && !idx_wr) |=>
            ($stable(idx_q) && $stable(rd_entry_a)));

endmodule

// File: rtl/adc_cfg_decode.sv
`timescale 1ns/1ps
// adc_cfg_decode
// Splits one configuration entry into its fields and flags a channel code
// that cannot be converted in the entry's mode. Purely combinational.
module adc_cfg_decode
    import adc_cfg_pkg::*;
(
    input  cfg_entry_t        entry,
    output logic [GAIN_W-1:0] gain,
    output logic [LOC_W-1:0]  alt_loc,
    output logic              acq_ext,
    output logic              align_left,
    output logic              diff,
    output logic [CHAN_W-1:0] chan,
    output logic              chan_invalid
);

    // Field extraction from the packed entry.
    always_comb begin
        gain       = entry.gain;
        alt_loc    = entry.alt_loc;
        acq_ext    = entry.acq_ext;
        align_left = entry.align_left;
        diff       = entry.diff;
        chan       = entry.chan;
    end

    // Validity flag from the shared channel rule.
    always_comb begin
        chan_invalid = !chan_ok(entry.diff, entry.chan);
    end

    // Guard the stored layout and the reserved band of channel codes.
    always_comb begin
        assert_rsvd_zero_R5: assert (entry.rsvd == 1'b0);
        if (entry.chan >= 5'd20 && entry.chan <= 5'd24) begin
            assert_bad_band_R7: assert (chan_invalid);
        end
        if (entry.chan <= 5'd7) begin
            assert_ext_ok_R7: assert (!chan_invalid);
        end
    end

endmodule

// File: rtl/adc_cfg_formatter.sv
`timescale 1ns/1ps
// adc_cfg_formatter
// Registers a finished conversion into a 16-bit word and a store address.
// Assumes the entry fields on align_in/loc_in belong to conv_entry in the
// strobe cycle. Outputs are valid one cycle after conv_done.
module adc_cfg_formatter
    import adc_cfg_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [IDX_W-1:0]  conv_entry,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              loc_override,
    input  logic              align_in,
    input  logic [LOC_W-1:0]  loc_in,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_addr,
    output logic [WORD_W-1:0] res_word
);

    localparam int PAD_W = WORD_W - RES_W;

    logic [WORD_W-1:0] word_left;
    logic [WORD_W-1:0] word_right;
    logic [WORD_W-1:0] word_pick;
    logic [IDX_W-1:0]  addr_pick;

    // Both packings; pad width derived from the word and result widths.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                word_left  = {conv_result, {PAD_W{1'b0}}};
                word_right = {{PAD_W{conv_result[RES_W-1]}}, conv_result};
            end
        end else begin : g_nopad
            always_comb begin
                word_left  = conv_result;
                word_right = conv_result;
            end
        end
    endgenerate

    // Choose packing and destination for this conversion.
    always_comb begin
        word_pick = align_in ? word_left : word_right;
        addr_pick = loc_override ? IDX_W'(loc_in) : conv_entry;
    end

    // Output stage: strobe for one cycle, hold word and address between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_we   <= 1'b0;
            res_addr <= '0;
            res_word <= '0;
        end else begin
            res_we <= conv_done;
            if (conv_done) begin
                res_addr <= addr_pick;
                res_word <= word_pick;
            end
        end
    end

    // Strobe follows every finished conversion and nothing else (R9).
    assert_we_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> res_we);
    assert_we_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> !res_we);

    // Default destination is the entry number itself (R9).
    assert_default_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !loc_override) |=> (res_addr == $past(conv_entry)));

    // Left packing pads the low bits with zero (R8).
    assert_left_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && align_in) |=> (res_word[1:0] == 2'b00));

    // Right packing copies the result sign into the top bits (R8).
    assert_sign_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !align_in) |=>
            (res_word[WORD_W-1] == $past(conv_result[RES_W-1])) &&
            (res_word[RES_W] == $past(conv_result[RES_W-1])));

endmodule

// File: rtl/adc_cfg_bank.sv
`timescale 1ns/1ps
// adc_cfg_bank
// Top of the ADC configuration bank: indexed storage behind one data port,
// field decode of the pointed entry, and the conversion result formatter.
// Assumes a single clock, synchronous active-low reset, and that the
// sequencer presents conv_entry with conv_done.
module adc_cfg_bank
    import adc_cfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              avg_sel,
    input  logic              conv_busy,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_wdata,
    output logic [IDX_W-1:0]  idx_o,
    output logic [WORD_W-1:0] rd_data,
    output logic [GAIN_W-1:0] sel_gain,
    output logic [LOC_W-1:0]  sel_alt_loc,
    output logic              sel_acq_ext,
    output logic              sel_align_left,
    output logic              sel_diff,
    output logic [CHAN_W-1:0] sel_chan,
    output logic              sel_chan_invalid,
    input  logic              conv_done,
    input  logic [IDX_W-1:0]  conv_entry,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              loc_override,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_addr,
    output logic [WORD_W-1:0] res_word
);

    cfg_entry_t       entry_a;
    logic             align_b;
    logic [LOC_W-1:0] loc_b;

    adc_cfg_regfile #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .avg_sel    (avg_sel),
        .conv_busy  (conv_busy),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .idx_wr     (idx_wr),
        .idx_wdata  (idx_wdata),
        .idx_q      (idx_o),
        .rd_entry_a (entry_a),
        .rd_idx_b   (conv_entry),
        .rd_align_b (align_b),
        .rd_loc_b   (loc_b)
    );

    // Raw readback of the pointed entry.
    always_comb begin
        rd_data = WORD_W'(entry_a);
    end

    adc_cfg_decode u_dec (
        .entry        (entry_a),
        .gain         (sel_gain),
        .alt_loc      (sel_alt_loc),
        .acq_ext      (sel_acq_ext),
        .align_left   (sel_align_left),
        .diff         (sel_diff),
        .chan         (sel_chan),
        .chan_invalid (sel_chan_invalid)
    );

    adc_cfg_formatter #(
        .IDX_W (IDX_W)
    ) u_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done),
        .conv_entry   (conv_entry),
        .conv_result  (conv_result),
        .loc_override (loc_override),
        .align_in     (align_b),
        .loc_in       (loc_b),
        .res_we       (res_we),
        .res_addr     (res_addr),
        .res_word     (res_word)
    );

    // Reading never moves the pointer when no write or load is pending (R6).
    assert_read_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !idx_wr) |=> $stable(idx_o));

    // Override sends the result to the alternate field of that entry (R9).
    assert_alt_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && loc_override && !wr_en) |=> (res_addr == IDX_W'($past(loc_b))));

endmodule

// File: tb/sim_adc_cfg_bank.sv
`timescale 1ns/1ps
// sim_adc_cfg_bank: vector table walk plus directed reset and gating tests.
module sim_adc_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_sel, avg_sel, conv_busy, wr_en, idx_wr;
    logic [15:0] wr_data;
    logic [4:0]  idx_wdata;
    logic [4:0]  idx_o;
    logic [15:0] rd_data;
    logic [1:0]  sel_gain;
    logic [4:0]  sel_alt_loc;
    logic        sel_acq_ext, sel_align_left, sel_diff;
    logic [4:0]  sel_chan;
    logic        sel_chan_invalid;
    logic        conv_done, loc_override;
    logic [4:0]  conv_entry;
    logic [13:0] conv_result;
    logic        res_we;
    logic [4:0]  res_addr;
    logic [15:0] res_word;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .avg_sel(avg_sel),
        .conv_busy(conv_busy), .wr_en(wr_en), .wr_data(wr_data),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata), .idx_o(idx_o),
        .rd_data(rd_data), .sel_gain(sel_gain), .sel_alt_loc(sel_alt_loc),
        .sel_acq_ext(sel_acq_ext), .sel_align_left(sel_align_left),
        .sel_diff(sel_diff), .sel_chan(sel_chan),
        .sel_chan_invalid(sel_chan_invalid), .conv_done(conv_done),
        .conv_entry(conv_entry), .conv_result(conv_result),
        .loc_override(loc_override), .res_we(res_we), .res_addr(res_addr),
        .res_word(res_word)
    );

    typedef struct packed {
        logic [4:0]  idx;
        logic [15:0] cfg;
        logic [13:0] res;
        logic        ovr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  16'h0000, 14'h1FFF, 1'b0},
        '{5'd3,  16'hFFFF, 14'h2001, 1'b1},
        '{5'd31, 16'h0528, 14'h3FFF, 1'b1},
        '{5'd7,  16'h0008, 14'h2000, 1'b0},
        '{5'd12, 16'h4C79, 14'h1234, 1'b1},
        '{5'd20, 16'h0094, 14'h0ABC, 1'b0},
        '{5'd9,  16'h2027, 14'h2ABC, 1'b0},
        '{5'd1,  16'h0053, 14'h0001, 1'b1}
    };

    // Channel rule from R7, written as a list of valid codes.
    function automatic logic exp_bad(input logic d, input logic [4:0] c);
        case (c)
            5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
            5'd16, 5'd17, 5'd18, 5'd19, 5'd25: return 1'b0;
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15: return d;
            default: return 1'b1;
        endcase
    endfunction

    // Packing rule from R8.
    function automatic logic [15:0] exp_word(input logic left, input logic [13:0] r);
        if (left) return {r, 2'b00};
        return {r[13], r[13], r};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one clock; returns at the following falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_idx(input logic [4:0] v);
        idx_wr = 1'b1; idx_wdata = v;
        cyc();
        idx_wr = 1'b0;
    endtask

    task automatic port_write(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_sel = 1'b1; avg_sel = 1'b0; conv_busy = 1'b0;
        wr_en = 1'b0; wr_data = '0; idx_wr = 1'b0; idx_wdata = '0;
        conv_done = 1'b0; conv_entry = '0; conv_result = '0; loc_override = 1'b0;
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R4: reset state
        chk("R4", "idx after reset", idx_o, 0);
        chk("R4", "entry0 after reset", rd_data, 0);
        chk("R4", "res_we after reset", res_we, 0);
        chk("R4", "res_addr after reset", res_addr, 0);
        chk("R4", "res_word after reset", res_word, 0);

        // Table walk: R1, R2, R5, R6, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] st;
            v  = VECS[i];
            st = v.cfg & 16'h7FFF;
            load_idx(v.idx);
            port_write(v.cfg);
            chk("R2", "idx after write", idx_o, (int'(v.idx) + 1) % 32);
            load_idx(v.idx);
            cyc();
            chk("R6", "read keeps idx", idx_o, v.idx);
            chk("R5", "readback bit15 clear", rd_data, st);
            chk("R6", "gain field", sel_gain, st[14:13]);
            chk("R6", "alt field", sel_alt_loc, st[12:8]);
            chk("R6", "acq field", sel_acq_ext, st[7]);
            chk("R6", "align field", sel_align_left, st[6]);
            chk("R6", "diff field", sel_diff, st[5]);
            chk("R6", "chan field", sel_chan, st[4:0]);
            chk("R7", "invalid flag", sel_chan_invalid, exp_bad(st[5], st[4:0]));
            conv_done = 1'b1; conv_entry = v.idx; conv_result = v.res;
            loc_override = v.ovr;
            cyc();
            conv_done = 1'b0; loc_override = 1'b0;
            chk("R9", "res_we after done", res_we, 1);
            chk("R9", "res_addr", res_addr, v.ovr ? st[12:8] : v.idx);
            chk("R8", "res_word", res_word, exp_word(st[6], v.res));
            cyc();
            chk("R9", "res_we one cycle", res_we, 0);
            chk("R9", "res_word held", res_word, exp_word(st[6], v.res));
        end

        // R1: write not routed to the bank (cfg_sel low)
        load_idx(5'd4);
        cfg_sel = 1'b0;
        port_write(16'h1234);
        chk("R1", "idx, cfg_sel low", idx_o, 4);
        chk("R1", "entry, cfg_sel low", rd_data, 0);
        // R1: averaging selected
        cfg_sel = 1'b1; avg_sel = 1'b1;
        port_write(16'h1234);
        avg_sel = 1'b0;
        chk("R1", "idx, avg_sel high", idx_o, 4);
        chk("R1", "entry, avg_sel high", rd_data, 0);

        // R3: conversion busy
        conv_busy = 1'b1;
        port_write(16'h0AA5);
        chk("R3", "idx while busy", idx_o, 4);
        chk("R3", "entry while busy", rd_data, 0);
        conv_busy = 1'b0;
        port_write(16'h0AA5);
        load_idx(5'd4);
        chk("R1", "accepted after busy", rd_data, 16'h0AA5);

        // R2: back-to-back writes fill neighbours and wrap
        load_idx(5'd30);
        port_write(16'h0011);
        port_write(16'h0012);
        port_write(16'h0013);
        chk("R2", "idx after three writes", idx_o, 1);
        load_idx(5'd31);
        chk("R2", "entry31", rd_data, 16'h0012);
        load_idx(5'd0);
        chk("R2", "entry0 after wrap", rd_data, 16'h0013);

        // R7: internal offset code valid in differential mode, 26 never valid
        load_idx(5'd5);
        port_write(16'h0039);
        load_idx(5'd5);
        chk("R7", "code25 diff", sel_chan_invalid, 0);
        port_write(16'h001A);
        load_idx(5'd5);
        chk("R7", "code26", sel_chan_invalid, 1);

        // R4: reset clears written entries and pointer
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        load_idx(5'd12);
        chk("R4", "entry12 after reset", rd_data, 0);
        load_idx(5'd4);
        chk("R4", "entry4 after reset", rd_data, 0);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        chk("R4", "idx after second reset", idx_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule